// File: doc/BRIEF.md
# Two-Wire Register Pointer Slave

This block is the serial front end of a small register file. A host on a two-wire bus (SCL clock, SDA data, open-drain) reads and writes byte-wide registers through it. The block samples both bus lines with the local system clock and rejects short spikes on each line. It recognises start, repeated start and stop conditions, compares the first byte of each transfer with its fixed 7-bit bus address, and acknowledges each byte it accepts. SDA is never driven high. The block only pulls it low, and it shows this on a single drive-low output.

An 8-bit pointer selects the register. In a write transfer the first byte after the address always reloads the pointer, and each byte after that is written to the register the pointer selects. A read transfer begins at the pointer as it stands. The pointer keeps its value from one transfer to the next, so a read that starts with no pointer byte continues where the last access stopped. To read from a new location, the host sends a pointer byte and then a repeated start. The pointer advances after every data byte in either direction.

The register file sits outside the block on a plain register port: an address, write data, a one-cycle write strobe and combinational read data. Pointer values at or above the register count are handled inside the block.

Top module: `i2cPtrSlave`

## Requirements
- R1: The first byte after a start is taken as a 7-bit address (bits 7:1) and a direction flag (bit 0; 0 = host writes, 1 = host reads). When bits 7:1 equal SLAVE_ADDR (default 0x06), the block pulls SDA low for the ninth clock. Otherwise it leaves SDA released for that clock.
- R2: After an address mismatch, the block keeps SDA released and produces no register write until the next start or stop. The pointer is left unchanged.
- R3: In a write transfer the first byte after the address is loaded into the pointer and acknowledged. The pointer keeps its value after a stop.
- R4: Each later byte of a write transfer, including one that follows the pointer byte without a repeated start, is acknowledged and written as a one-cycle strobe with address = pointer and data = byte. The pointer then advances by one.
- R5: A read transfer drives the register at the current pointer onto SDA, MSB first, starting with the clock after the address acknowledge. The pointer advances by one after each byte sent and wraps from 0xFF to 0x00.
- R6: In a read, a host acknowledge (SDA low on the ninth clock) makes the block send the next register. A host not-acknowledge makes it release SDA and wait for a start or stop.
- R7: A start (SDA falling while SCL is high) restarts address reception in any state, so a repeated start is valid mid-transfer. A stop (SDA rising while SCL is high) returns the block to idle.
- R8: Pointer values of NUM_REGS (default 21) or above read as 0x00. A write to such a value produces no strobe, but the byte is still acknowledged and the pointer still advances.
- R9: A pulse of up to SPIKE_CYCLES system clocks (default 10, which is 50 ns at 200 MHz) on SCL or SDA has no effect on the transfer.
- R10: The SDA drive-low output changes only while the filtered SCL is low, and it is released while the block waits for the host's acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired with the block's own drive) |
| sdaDrvLow | output | 1 | 1 = pull SDA low, 0 = release it |
| regAddr | output | 8 | Register address (the pointer) |
| regWrData | output | 8 | Byte to write |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdData | input | 8 | Contents of the register at regAddr |

## Verification
The assertions assume that the host obeys bus framing. It changes SDA only while SCL is low, except when it makes a start or a stop. It never tries to make a start or stop while the block holds SDA low. SCL high and low phases are much longer than the filter window. The bench host drives SDA a quarter period after each SCL edge, uses phases of 30 system clocks, and sends stops only after a not-acknowledge or after a write byte. Its only deliberate rule-breaking is a set of spikes of 8 clocks, shorter than the filter window, placed on each line.

// File: rtl/i2cPtrSlavePkg.sv
package i2cPtrSlavePkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_MACK
  } slvState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic loadPtr;
    logic incPtr;
    logic writeEn;
  } slvStrobe_t;

endpackage

// File: rtl/i2cSlvGlitchFilt.sv
module i2cSlvGlitchFilt #(
  parameter int   SPIKE_CYCLES = 10,
  parameter logic INIT_LEVEL   = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int HOLD_CYCLES = SPIKE_CYCLES + 1;
  localparam int CNT_W       = $clog2(HOLD_CYCLES + 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= {2{INIT_LEVEL}};
      runLen   <= '0;
      cleanOut <= INIT_LEVEL;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        runLen <= '0;
      end else if (runLen == CNT_W'(HOLD_CYCLES - 1)) begin
        cleanOut <= syncQ[1];
        runLen   <= '0;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cSlvCtrl.sv
module i2cSlvCtrl
  import i2cPtrSlavePkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h06
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [3:0] bitCnt,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output slvStrobe_t strb,
  output slvState_t  state,
  output logic       sdaDrvLow
);
  logic      sclD, sdaD;
  logic      sclRise, sclFall, startEv, stopEv;
  logic      addrHit;
  slvState_t nxtState, ackNext, nxtAckNext;
  logic      hostAck, nxtHostAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
      state   <= ST_IDLE;
      ackNext <= ST_IDLE;
      hostAck <= 1'b0;
    end else begin
      sclD    <= sclF;
      sdaD    <= sdaF;
      state   <= nxtState;
      ackNext <= nxtAckNext;
      hostAck <= nxtHostAck;
    end
  end

  assign sclRise = sclF & ~sclD;
  assign sclFall = ~sclF & sclD;
  assign startEv = sclF & sclD & sdaD & ~sdaF;
  assign stopEv  = sclF & sclD & ~sdaD & sdaF;
  assign addrHit = (rxByte[7:1] == SLAVE_ADDR);

  always_comb begin
    strb       = '0;
    nxtState   = state;
    nxtAckNext = ackNext;
    nxtHostAck = hostAck;
    if (stopEv) begin
      nxtState = ST_IDLE;
    end else if (startEv) begin
      nxtState    = ST_ADDR;
      strb.clrCnt = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise) begin
            strb.shiftIn = 1'b1;
            strb.incCnt  = 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state == ST_ADDR) begin
              if (addrHit) begin
                nxtState   = ST_ACK;
                nxtAckNext = rxByte[0] ? ST_TX : ST_PTR;
              end else begin
                nxtState = ST_IDLE;
              end
            end else if (state == ST_PTR) begin
              strb.loadPtr = 1'b1;
              nxtState     = ST_ACK;
              nxtAckNext   = ST_WDATA;
            end else begin
              strb.writeEn = 1'b1;
              strb.incPtr  = 1'b1;
              nxtState     = ST_ACK;
              nxtAckNext   = ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            nxtState    = ackNext;
            strb.clrCnt = 1'b1;
            if (ackNext == ST_TX) strb.loadTx = 1'b1;
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              nxtState    = ST_MACK;
              strb.incPtr = 1'b1;
            end else begin
              strb.shiftOut = 1'b1;
              strb.incCnt   = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            nxtHostAck = ~sdaF;
          end else if (sclFall) begin
            if (hostAck) begin
              nxtState    = ST_TX;
              strb.loadTx = 1'b1;
              strb.clrCnt = 1'b1;
            end else begin
              nxtState = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaDrvLow = (state == ST_ACK) | ((state == ST_TX) & ~txMsb);
endmodule

// File: rtl/i2cSlvDpath.sv
module i2cSlvDpath
  import i2cPtrSlavePkg::*;
#(
  parameter int NUM_REGS = 21,
  parameter int PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  slvStrobe_t       strb,
  input  logic             sdaF,
  output logic [3:0]       bitCnt,
  output logic [7:0]       rxByte,
  output logic             txMsb,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regWrData,
  output logic             regWrEn,
  input  logic [7:0]       regRdData
);
  logic [PTR_W-1:0] ptr;
  logic [7:0]       txShift;
  logic             inRange;
  logic [7:0]       rdMasked;

  assign inRange  = (32'(ptr) < NUM_REGS);
  assign rdMasked = inRange ? regRdData : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxByte  <= '0;
      txShift <= 8'hFF;
      ptr     <= '0;
    end else begin
      if (strb.clrCnt)      bitCnt <= '0;
      else if (strb.incCnt) bitCnt <= bitCnt + 1'b1;

      if (strb.shiftIn) rxByte <= {rxByte[6:0], sdaF};

      if (strb.loadTx)        txShift <= rdMasked;
      else if (strb.shiftOut) txShift <= {txShift[6:0], 1'b1};

      if (strb.loadPtr)     ptr <= PTR_W'(rxByte);
      else if (strb.incPtr) ptr <= ptr + 1'b1;
    end
  end

  assign txMsb     = txShift[7];
  assign regAddr   = ptr;
  assign regWrData = rxByte;
  assign regWrEn   = strb.writeEn & inRange;
endmodule

// File: rtl/i2cPtrSlave.sv
module i2cPtrSlave
  import i2cPtrSlavePkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR   = 7'h06,
  parameter int         NUM_REGS     = 21,
  parameter int         SPIKE_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDrvLow,
  output logic [7:0] regAddr,
  output logic [7:0] regWrData,
  output logic       regWrEn,
  input  logic [7:0] regRdData
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLines, cleanLines;
  logic                 sclF, sdaF;
  logic [3:0]           bitCnt;
  logic [7:0]           rxByte;
  logic                 txMsb;
  slvStrobe_t           strb;
  slvState_t            ctrlState;
  logic                 incPtrStb;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    i2cSlvGlitchFilt #(
      .SPIKE_CYCLES(SPIKE_CYCLES),
      .INIT_LEVEL  (1'b1)
    ) uFilt (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawLines[g]),
      .cleanOut(cleanLines[g])
    );
  end

  assign sclF      = cleanLines[0];
  assign sdaF      = cleanLines[1];
  assign incPtrStb = strb.incPtr;

  i2cSlvCtrl #(.SLAVE_ADDR(SLAVE_ADDR)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclF     (sclF),
    .sdaF     (sdaF),
    .bitCnt   (bitCnt),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .strb     (strb),
    .state    (ctrlState),
    .sdaDrvLow(sdaDrvLow)
  );

  i2cSlvDpath #(.NUM_REGS(NUM_REGS), .PTR_W(8)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .sdaF     (sdaF),
    .bitCnt   (bitCnt),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWrEn  (regWrEn),
    .regRdData(regRdData)
  );
endmodule

// File: rtl/i2cPtrSlaveChk.sv
module i2cPtrSlaveChk
  import i2cPtrSlavePkg::*;
#(
  parameter int NUM_REGS = 21
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclF,
  input logic       sdaDrvLow,
  input logic       regWrEn,
  input logic [7:0] regAddr,
  input slvState_t  ctrlState,
  input logic       incPtrStb
);
  // R4: write strobe lasts exactly one cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R8: no strobe for addresses outside the register file
  a_r8_no_oob_write: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (32'(regAddr) < NUM_REGS));

  // R10: drive changes only while the clock line is low
  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrvLow != $past(sdaDrvLow)) |-> !sclF);

  // R6, R10: line released while the host answers
  a_r6_release_host_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_MACK) |-> !sdaDrvLow);

  // R2: idle means released
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IDLE) |-> (!sdaDrvLow && !regWrEn));

  // R5: pointer step of one with 8-bit wrap
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    incPtrStb |=> (regAddr == 8'($past(regAddr) + 8'd1)));
endmodule

bind i2cPtrSlave i2cPtrSlaveChk #(.NUM_REGS(NUM_REGS)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .sclF     (sclF),
  .sdaDrvLow(sdaDrvLow),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .ctrlState(ctrlState),
  .incPtrStb(incPtrStb)
);

// File: tb/i2cPtrSlave_test.sv
module i2cPtrSlave_test;
  localparam int       NREG = 21;
  localparam int       Q    = 30;
  localparam bit [6:0] DEV  = 7'h06;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaBus;
  logic       sdaDrvLow;
  logic [7:0] regAddr, regWrData, regRdData;
  logic       regWrEn;

  logic [7:0]  mem    [NREG];
  logic [7:0]  expMem [NREG];
  logic [7:0]  expPtr;
  logic [15:0] wrQ [$];
  logic [7:0]  rdQ [$];
  int          nChecks = 0;
  int          nFail   = 0;
  bit          glitchOn = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  assign sdaBus    = sdaM & ~sdaDrvLow;
  assign regRdData = (32'(regAddr) < NREG) ? mem[regAddr] : 8'hAA;

  i2cPtrSlave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDrvLow(sdaDrvLow), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: every write strobe must match the next expected write
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      if (wrQ.size() == 0) begin
        check(0, "R2/R8 unexpected write", {regAddr, regWrData}, 0);
      end else begin
        logic [15:0] e;
        e = wrQ.pop_front();
        check({regAddr, regWrData} == e, "R4 write", {regAddr, regWrData}, e);
      end
      mem[regAddr] <= regWrData;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1; sclM = 1; waitClk(Q);
    sdaM = 0; waitClk(Q);
    sclM = 0; waitClk(Q);
  endtask

  task automatic busRestart();
    sdaM = 1; waitClk(Q);
    sclM = 1; waitClk(Q);
    sdaM = 0; waitClk(Q);
    sclM = 0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaM = 0; waitClk(Q);
    sclM = 1; waitClk(Q);
    sdaM = 1; waitClk(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i];
      if (glitchOn && i == 4) begin
        waitClk(5); sclM = 1; waitClk(8); sclM = 0; waitClk(Q - 13);
      end else begin
        waitClk(Q);
      end
      sclM = 1;
      if (glitchOn && i == 1 && b[i]) begin
        waitClk(5); sdaM = 0; waitClk(8); sdaM = 1; waitClk(2 * Q - 13);
      end else begin
        waitClk(2 * Q);
      end
      sclM = 0; waitClk(Q);
    end
    sdaM = 1; waitClk(Q);
    sclM = 1; waitClk(Q);
    acked = ~sdaBus;
    waitClk(Q);
    sclM = 0; waitClk(Q);
  endtask

  task automatic recvByte(input bit hostAck, output logic [7:0] b);
    sdaM = 1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(Q); sclM = 1; waitClk(Q);
      b[i] = sdaBus;
      waitClk(Q); sclM = 0;
    end
    waitClk(Q / 2);
    sdaM = ~hostAck; waitClk(Q / 2);
    sclM = 1; waitClk(2 * Q);
    sclM = 0; waitClk(Q / 2);
    check(sdaDrvLow == 0 || hostAck, "R6 release after NACK", sdaDrvLow, 0);
    waitClk(Q / 2);
  endtask

  task automatic wrTxn(input logic [7:0] ptr, input logic [7:0] dq[$]);
    bit a;
    busStart();
    sendByte({DEV, 1'b0}, a); check(a, "R1 address ack (write)", a, 1);
    sendByte(ptr, a);         check(a, "R3 pointer ack", a, 1);
    expPtr = ptr;
    foreach (dq[k]) begin
      if (32'(expPtr) < NREG) begin
        wrQ.push_back({expPtr, dq[k]});
        expMem[expPtr] = dq[k];
      end
      sendByte(dq[k], a); check(a, "R4/R8 data ack", a, 1);
      expPtr = expPtr + 1;
    end
    busStop();
    check(wrQ.size() == 0, "R4 pending writes", wrQ.size(), 0);
  endtask

  task automatic rdTxn(input bit setPtr, input logic [7:0] ptr, input int n, input string tag);
    bit a;
    logic [7:0] got, e;
    busStart();
    if (setPtr) begin
      sendByte({DEV, 1'b0}, a); check(a, "R1 address ack (write)", a, 1);
      sendByte(ptr, a);         check(a, "R3 pointer ack", a, 1);
      expPtr = ptr;
      busRestart();
    end
    sendByte({DEV, 1'b1}, a); check(a, "R1 address ack (read)", a, 1);
    for (int k = 0; k < n; k++) begin
      rdQ.push_back((32'(expPtr) < NREG) ? expMem[expPtr] : 8'h00);
      expPtr = expPtr + 1;
    end
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, got);
      e = rdQ.pop_front();
      check(got == e, tag, got, e);
    end
    busStop();
    check(sdaDrvLow == 0, "R6 released at stop", sdaDrvLow, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    bit a;
    for (int i = 0; i < NREG; i++) begin
      mem[i]    = 8'h40 + 8'(i);
      expMem[i] = 8'h40 + 8'(i);
    end
    expPtr = 8'h00;
    waitClk(10);
    check(sdaDrvLow == 0 && regWrEn == 0, "R10 reset released", {sdaDrvLow, regWrEn}, 0);
    rstN = 1;
    waitClk(20);

    // R3 R4: pointer then three bytes written with increment
    wrTxn(8'h02, '{8'h11, 8'h22, 8'h33});
    // R5 R6 R7: pointer set, repeated start, multi-byte read
    rdTxn(1, 8'h02, 3, "R5 read after restart");
    // R3 R5: plain read continues at retained pointer
    rdTxn(0, 8'h00, 2, "R3 retained pointer read");

    // R1 R2: foreign address ignored
    busStart();
    sendByte({7'h07, 1'b0}, a); check(!a, "R1 no ack other address", a, 0);
    sendByte(8'h03, a);         check(!a, "R2 ignored byte", a, 0);
    sendByte(8'h55, a);         check(!a, "R2 ignored byte", a, 0);
    busStop();
    rdTxn(0, 8'h00, 1, "R2 pointer untouched");

    // R8: last register written, next suppressed, read beyond returns zero
    wrTxn(8'h14, '{8'hA5, 8'h5A});
    rdTxn(1, 8'h13, 3, "R8 read out of range");
    // R5: pointer wrap 0xFF -> 0x00
    rdTxn(1, 8'hFF, 2, "R5 pointer wrap");

    // R3: pointer-only write, then plain read from it
    wrTxn(8'h0A, '{});
    rdTxn(0, 8'h00, 1, "R3 pointer only");

    // R9: spikes on both lines during a write
    glitchOn = 1;
    wrTxn(8'h08, '{8'hC3, 8'h3E});
    glitchOn = 0;
    rdTxn(1, 8'h08, 2, "R9 spike rejected");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule